// File: doc/BRIEF.md
# Single-Word DMA Handshake Cycle Sequencer

This block runs one granted single-word DMA bus cycle between memory and an I/O port that requested it. Once the bus is granted and `start` is pulsed, it raises the address strobe, asserts the channel acknowledge toward the port and drives the memory strobe for the chosen direction. It then stretches the cycle with a request/acknowledge handshake. On a memory read, the port is given a latch strobe once memory is ready, and the cycle holds until the port drops its request. On a memory write, the memory write strobe waits until the port drops its request, which signals that its data is valid.

The sequencer falls back to a plain ready-terminated cycle in two cases: the port request has already been inactive long enough before the handshake point, or a software-initiated transfer finds no hardware request. A bus-timeout timer aborts any cycle that stalls in a wait state and reports the abort with a one-clock error pulse. Address generation, arbitration and multi-word modes sit outside this block.

States: `S_IDLE` (bus released), `S_ADDR` (first clock: address strobe and acknowledge), `S_RDMEM` (memory read strobe, waiting for ready), `S_HSRD` (read handshake: port latch strobe, waiting for the request to drop), `S_PORT` (write handshake: port drives data, waiting for the request to drop), `S_MEMWR` (memory write strobe, waiting for ready), `S_CLOSE` (acknowledge released, cycle finishing, `done`), `S_ABORT` (timeout, everything released, `tmo_err`). Transitions: IDLE→ADDR on start; ADDR→RDMEM (read), ADDR→PORT (write, handshake), ADDR→MEMWR (write, ready-only); RDMEM→HSRD (ready, handshake), RDMEM→CLOSE (ready, ready-only); HSRD→CLOSE and PORT→MEMWR when the request is seen inactive; MEMWR→CLOSE on ready; any wait state→ABORT on timeout; CLOSE→IDLE and ABORT→IDLE always.

Top module: `dma_hs_cycle`

## Requirements
- R1: After reset and while idle, `ack_n`, `rd_n`, `wr_n`, `pstb_wr_n` and `pstb_rd_n` are high, and `as_o`, `data_en`, `done`, `tmo_err` and `busy` are low.
- R2: The clock cycle after `start` is sampled high in idle asserts `as_o` high and `ack_n` low with both memory strobes still high. A read with memory ready at once and no handshake keeps `ack_n` low for exactly 2 clocks.
- R3: On a read (`dir_wr`=0) in handshake mode, the edge that samples `mem_rdy_n` low drives `pstb_wr_n` low while `ack_n` stays low. `ack_n` stays low until an edge samples `chan_req_n` high.
- R4: On a write (`dir_wr`=1) in handshake mode, `pstb_rd_n` goes low after the address clock and `wr_n` stays high until an edge samples `chan_req_n` high. Then `wr_n` is low and `data_en` high, with `ack_n` still low, until an edge samples `mem_rdy_n` low.
- R5: The handshake is skipped when `chan_req_n` was sampled high on each of the 2 clock edges before the decision edge. For a read the decision edge is the one that samples ready low; for a write it is the edge that leaves the address clock. If only 1 such edge saw it high, the handshake is kept.
- R6: If `sw_init` was high at start and `chan_req_n` is high at the decision edge, the cycle is ready-only. `ack_n` is released on the edge that samples `mem_rdy_n` low.
- R7: Every completed cycle ends with one clock where `done`=1, `ack_n` is high, and `as_o`, the direction's memory strobe and its port strobe are still active. On the next clock all of them are released together.
- R8: If the sequencer spends 256 consecutive clocks in one wait state (RDMEM, HSRD, PORT, MEMWR), it aborts. It gives one clock with `tmo_err`=1 and every strobe and acknowledge released, with no `done`.
- R9: While `tmo_en` is low, the timeout counter is held cleared and no timeout is raised, however long the cycle waits.
- R10: `start` is ignored while a cycle is in progress: the running cycle's length is unchanged and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one cycle (bus already granted) |
| dir_wr | input | 1 | 0 = memory read to port, 1 = memory write from port; latched at start |
| sw_init | input | 1 | Transfer was requested by software; latched at start |
| chan_req_n | input | 1 | Port request line, active low |
| mem_rdy_n | input | 1 | Memory ready, active low |
| tmo_en | input | 1 | Low clears and disables the bus timeout |
| ack_n | output | 1 | Channel acknowledge to the port, active low |
| pstb_wr_n | output | 1 | Port latch strobe on memory reads, active low |
| pstb_rd_n | output | 1 | Port drive strobe on memory writes, active low |
| as_o | output | 1 | Address strobe, high while the cycle owns the address |
| rd_n | output | 1 | Memory read strobe, active low |
| wr_n | output | 1 | Memory write strobe, active low |
| data_en | output | 1 | Port data is being written to memory |
| done | output | 1 | One-clock pulse at cycle completion |
| tmo_err | output | 1 | One-clock pulse on bus timeout abort |
| busy | output | 1 | A cycle is in progress |

## Verification
The embedded assertions check on every clock the relations that hold in any run. Acknowledge never falls without the address strobe. `done` and `tmo_err` are single-clock pulses, and an abort releases every strobe. The address strobe never falls while a port strobe is still low. The write strobe never falls with acknowledge released. A disabled timer never expires, and `start` never restarts a busy cycle. Only the bench scenarios can show cycle lengths, because those depend on how long ready and the port request are held. The same goes for the choice between the handshake and ready-only paths at the two-clock early-drop boundary, and the exact 256-clock abort point.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_RDMEM = 3'd2,
        S_HSRD  = 3'd3,
        S_PORT  = 3'd4,
        S_MEMWR = 3'd5,
        S_CLOSE = 3'd6,
        S_ABORT = 3'd7
    } hs_state_e;

    function automatic logic is_wait_state(hs_state_e s);
        return (s == S_RDMEM) || (s == S_HSRD) || (s == S_PORT) || (s == S_MEMWR);
    endfunction

endpackage

// File: rtl/dma_hs_reqhist.sv
module dma_hs_reqhist #(
    parameter int EARLY_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_req_n,
    output logic early_drop
);
    localparam int HW = $clog2(EARLY_CLKS + 1);
    localparam logic [HW-1:0] SAT = HW'(EARLY_CLKS);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!chan_req_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != SAT) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign early_drop = (hi_cnt == SAT);

    AST_HIST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_req_n |=> !early_drop);  // R5

endmodule

// File: rtl/dma_hs_timer.sv
module dma_hs_timer #(
    parameter int TMO_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic waiting,
    input  logic restart,
    output logic expire
);
    localparam int CW = $clog2(TMO_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || !waiting || restart) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = enable && waiting && (cnt == LAST);

    AST_TMO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !expire);  // R9

endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
    import dma_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dir_wr,
    input  logic sw_init,
    input  logic chan_req_n,
    input  logic mem_rdy_n,
    input  logic early_drop,
    input  logic expire,
    output logic waiting,
    output logic restart,
    output logic ack_n,
    output logic pstb_wr_n,
    output logic pstb_rd_n,
    output logic as_o,
    output logic rd_n,
    output logic wr_n,
    output logic data_en,
    output logic done,
    output logic tmo_err,
    output logic busy
);
    hs_state_e state_q, state_d;
    logic      dir_q, sw_q;
    logic      ready_only;

    assign ready_only = early_drop || (sw_q && chan_req_n);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_ADDR;
            S_ADDR:  begin
                if (!dir_q)          state_d = S_RDMEM;
                else if (ready_only) state_d = S_MEMWR;
                else                 state_d = S_PORT;
            end
            S_RDMEM: begin
                if (!mem_rdy_n)  state_d = ready_only ? S_CLOSE : S_HSRD;
                else if (expire) state_d = S_ABORT;
            end
            S_HSRD:  begin
                if (chan_req_n)  state_d = S_CLOSE;
                else if (expire) state_d = S_ABORT;
            end
            S_PORT:  begin
                if (chan_req_n)  state_d = S_MEMWR;
                else if (expire) state_d = S_ABORT;
            end
            S_MEMWR: begin
                if (!mem_rdy_n)  state_d = S_CLOSE;
                else if (expire) state_d = S_ABORT;
            end
            S_CLOSE: state_d = S_IDLE;
            S_ABORT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dir_q   <= 1'b0;
            sw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                dir_q <= dir_wr;
                sw_q  <= sw_init;
            end
        end
    end

    assign waiting = is_wait_state(state_q);
    assign restart = (state_d != state_q);

    always_comb begin
        ack_n     = 1'b1;
        pstb_wr_n = 1'b1;
        pstb_rd_n = 1'b1;
        as_o      = 1'b0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        data_en   = 1'b0;
        done      = 1'b0;
        tmo_err   = 1'b0;
        busy      = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE:  ;
            S_ADDR:  begin as_o = 1'b1; ack_n = 1'b0; end
            S_RDMEM: begin as_o = 1'b1; ack_n = 1'b0; rd_n = 1'b0; end
            S_HSRD:  begin as_o = 1'b1; ack_n = 1'b0; rd_n = 1'b0; pstb_wr_n = 1'b0; end
            S_PORT:  begin as_o = 1'b1; ack_n = 1'b0; pstb_rd_n = 1'b0; end
            S_MEMWR: begin
                as_o = 1'b1; ack_n = 1'b0; pstb_rd_n = 1'b0; wr_n = 1'b0; data_en = 1'b1;
            end
            S_CLOSE: begin
                as_o = 1'b1;
                done = 1'b1;
                if (dir_q) begin wr_n = 1'b0; pstb_rd_n = 1'b0; end
                else       begin rd_n = 1'b0; pstb_wr_n = 1'b0; end
            end
            S_ABORT: tmo_err = 1'b1;
            default: ;
        endcase
    end

    AST_ACK_NEEDS_AS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> as_o);  // R2
    AST_HS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HSRD && !chan_req_n && !expire) |=> !ack_n);  // R3
    AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> !ack_n);  // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !as_o);  // R7
    AST_AS_FALL_PSTB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_o) |-> (pstb_wr_n && pstb_rd_n && rd_n && wr_n));  // R7
    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> (ack_n && !as_o && !done) ##1 !tmo_err);  // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != S_CLOSE && state_q != S_ABORT) |=> busy);  // R10

endmodule

// File: rtl/dma_hs_cycle.sv
module dma_hs_cycle #(
    parameter int TMO_CYCLES = 256,
    parameter int EARLY_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dir_wr,
    input  logic sw_init,
    input  logic chan_req_n,
    input  logic mem_rdy_n,
    input  logic tmo_en,
    output logic ack_n,
    output logic pstb_wr_n,
    output logic pstb_rd_n,
    output logic as_o,
    output logic rd_n,
    output logic wr_n,
    output logic data_en,
    output logic done,
    output logic tmo_err,
    output logic busy
);
    logic early_drop, expire, waiting, restart;

    dma_hs_reqhist #(.EARLY_CLKS(EARLY_CLKS)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_req_n (chan_req_n),
        .early_drop (early_drop)
    );

    dma_hs_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tmo_en),
        .waiting (waiting),
        .restart (restart),
        .expire  (expire)
    );

    dma_hs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir_wr     (dir_wr),
        .sw_init    (sw_init),
        .chan_req_n (chan_req_n),
        .mem_rdy_n  (mem_rdy_n),
        .early_drop (early_drop),
        .expire     (expire),
        .waiting    (waiting),
        .restart    (restart),
        .ack_n      (ack_n),
        .pstb_wr_n  (pstb_wr_n),
        .pstb_rd_n  (pstb_rd_n),
        .as_o       (as_o),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .data_en    (data_en),
        .done       (done),
        .tmo_err    (tmo_err),
        .busy       (busy)
    );

endmodule

// File: tb/dma_hs_cycle_test.sv
module dma_hs_cycle_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, dir_wr = 1'b0, sw_init = 1'b0;
    logic chan_req_n = 1'b1, mem_rdy_n = 1'b1, tmo_en = 1'b1;
    logic ack_n, pstb_wr_n, pstb_rd_n, as_o, rd_n, wr_n, data_en, done, tmo_err, busy;

    int n_checks = 0, n_fail = 0, wd = 0;
    int exp_kind_q[$];
    int exp_len_q[$];
    string exp_tag_q[$];
    int ack_run = 0;

    always #10 clk = ~clk;

    dma_hs_cycle uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            finish_run();
        end
    end

    // monitor: measures acknowledge length and outcome, compares against scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ack_n) ack_run++;
            if (done || tmo_err) begin
                if (exp_kind_q.size() == 0) begin
                    chk(0, "scoreboard-empty", 1, 0);
                end else begin
                    int k, l;
                    string t;
                    k = exp_kind_q.pop_front();
                    l = exp_len_q.pop_front();
                    t = exp_tag_q.pop_front();
                    chk(k == (tmo_err ? 1 : 0), {t, " outcome"}, tmo_err ? 1 : 0, k);
                    chk(l == ack_run, {t, " ack length"}, ack_run, l);
                end
                ack_run = 0;
            end
        end
    end

    // kind: 0 done, 1 timeout. pre_hi <0 : request low at start.
    task automatic run(input string tag, input bit dir, input bit sw, input bit port_on,
                       input int W, input int H, input int drop_at, input int pre_hi,
                       input int restart_at, input bit exp_hs, input int kind, input int len);
        int scnt = 0, pcnt = 0, i = 0;
        bit hs_seen = 0, wr_seen = 0;
        chan_req_n = 1'b0; mem_rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        if (pre_hi >= 0) begin
            chan_req_n = 1'b1;
            repeat (pre_hi) @(negedge clk);
        end
        exp_kind_q.push_back(kind);
        exp_len_q.push_back(len);
        exp_tag_q.push_back(tag);
        dir_wr = dir; sw_init = sw; start = 1'b1;
        while (i < 2000) begin
            @(negedge clk);
            i++;
            if (i == 1) begin
                start = 1'b0;
                chk(as_o && !ack_n && rd_n && wr_n, {tag, " R2 address clock"}, {as_o, ack_n}, 2'b10);
            end
            if (i == restart_at) start = 1'b1;
            if (i == restart_at + 1) start = 1'b0;
            if (!ack_n && ((!dir && !pstb_wr_n) || (dir && !pstb_rd_n && wr_n))) hs_seen = 1;
            if (!wr_n && !wr_seen) begin
                wr_seen = 1;
                if (exp_hs) chk(chan_req_n && data_en && !ack_n, {tag, " R4 write after request"},
                                {chan_req_n, data_en, ack_n}, 3'b110);
            end
            if (done) begin
                chk(ack_n && as_o && (dir ? (!wr_n && !pstb_rd_n) : (!rd_n && !pstb_wr_n)),
                    {tag, " R7 close clock"}, {ack_n, as_o}, 2'b11);
                chk(hs_seen == exp_hs, {tag, " R5 handshake path"}, hs_seen, exp_hs);
                @(negedge clk);
                chk(!as_o && pstb_wr_n && pstb_rd_n && rd_n && wr_n && !done,
                    {tag, " R7 joint release"}, as_o, 0);
                break;
            end
            if (tmo_err) begin
                chk(ack_n && !as_o && rd_n && wr_n && pstb_wr_n && pstb_rd_n && !done,
                    {tag, " R8 abort release"}, {ack_n, as_o}, 2'b10);
                @(negedge clk);
                break;
            end
            scnt = (!rd_n || !wr_n) ? scnt + 1 : 0;
            mem_rdy_n = !(scnt > W);
            if (port_on && !chan_req_n && !(dir ? pstb_rd_n : pstb_wr_n)) begin
                pcnt++;
                if (pcnt > H) chan_req_n = 1'b1;
            end
            if (i == drop_at) chan_req_n = 1'b1;
        end
        mem_rdy_n = 1'b1;
        sw_init = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(ack_n && pstb_wr_n && pstb_rd_n && rd_n && wr_n && !as_o && !data_en &&
            !done && !tmo_err && !busy, "R1 in reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ack_n && !as_o && !busy && !done, "R1 idle after reset", busy, 0);

        // R2 R6: software read, no hardware request, ready at once -> 2-clock cycle
        run("R2_R6 sw read", 0, 1, 0, 0, 0, -1, 5, -1, 0, 0, 2);
        // R3: read handshake, ready after 1 wait, port holds 3 clocks
        run("R3 read hs", 0, 0, 1, 1, 2, -1, -1, -1, 1, 0, 6);
        // R5: request high on two edges before ready -> ready-only
        run("R5 read early drop", 0, 0, 0, 3, 0, 3, -1, -1, 0, 0, 5);
        // R5: request high on one edge only -> handshake kept
        run("R5 read late drop", 0, 0, 0, 3, 0, 4, -1, -1, 1, 0, 6);
        // R4: write handshake
        run("R4 write hs", 1, 0, 1, 0, 1, -1, -1, -1, 1, 0, 4);
        // R5: write, request high one edge before decision -> handshake
        run("R5 write one edge", 1, 0, 0, 0, 0, -1, 0, -1, 1, 0, 3);
        // R5: write, request high two edges -> ready-only
        run("R5 write two edges", 1, 0, 0, 0, 0, -1, 1, -1, 0, 0, 2);
        // R6: software write, no request
        run("R6 sw write", 1, 1, 0, 2, 0, -1, 5, -1, 0, 0, 4);
        // R8: timeout waiting for ready
        run("R8 ready timeout", 0, 0, 0, 100000, 0, -1, -1, -1, 0, 1, 257);
        // R8: timeout in read handshake
        run("R8 handshake timeout", 0, 0, 1, 0, 100000, -1, -1, -1, 0, 1, 258);
        // R9: timer disabled, long wait completes
        tmo_en = 1'b0;
        run("R9 timer off", 0, 1, 0, 300, 0, -1, 5, -1, 0, 0, 302);
        tmo_en = 1'b1;
        // R10: start pulsed mid-cycle
        run("R10 start busy", 0, 1, 0, 3, 0, -1, 5, 2, 0, 0, 5);
        begin
            bit quiet = 1;
            repeat (4) begin
                @(negedge clk);
                if (!ack_n || busy || done) quiet = 0;
            end
            chk(quiet, "R10 no second cycle", quiet, 1);
        end
        chk(exp_kind_q.size() == 0, "scoreboard drained", exp_kind_q.size(), 0);
        finish_run();
    end

endmodule